// File: doc/BRIEF.md
# Return-Address Stack with Fault Detection

This block keeps the return addresses of a small processor core. A call or an interrupt entry writes the current program-counter value onto the stack with a push strobe. A return takes the newest value back with a pop strobe. The newest entry is shown on the output at all times, so the core reads the return target in the same cycle as the pop that removes it.

The stack is 16 entries of 15 bits. A push onto a full stack is recorded as an overflow, and a pop from an empty stack is recorded as an underflow. Each of these sets a sticky flag. When the fault-reset enable is high, a fault also raises a one-cycle reset request for the surrounding reset logic, and the faulting operation leaves the stack unchanged. When the enable is low, the pointer wraps and the stack keeps running. The flags survive the system reset that a fault request usually causes, so software can read why the restart happened. Only a power-on reset or the flag-clear strobe clears them.

The block is never busy and never applies back-pressure, so push and pop are plain single-cycle strobes rather than a valid/ready pair. The output word is a continuous view of the top slot, and the core may sample it whenever it needs to.

Top module: `retstack_top`

## Requirements
- R1: After power-on reset (rst_n low), ovf_flag, unf_flag and rst_req are 0 and the stack is empty.
- R2: After a push that causes no fault, top_addr shows the pushed value. Successive pops return values in last-in, first-out order.
- R3: A push and a pop in the same cycle act as a pop followed by a push. The top entry is replaced by push_addr, and the depth does not change.
- R4: A push without a pop while 16 entries are held sets ovf_flag in the next cycle.
- R5: A pop while the stack is empty sets unf_flag in the next cycle.
- R6: With fault_rst_en high, an overflow or underflow drives rst_req high for exactly the next cycle and leaves the pointer and the storage unchanged. With fault_rst_en low, rst_req stays 0.
- R7: ovf_flag and unf_flag stay set until flag_clr is high or rst_n is low. A set in the same cycle as flag_clr wins. sys_rst does not clear them.
- R8: With fault_rst_en low, an overflowing push overwrites the oldest entry and advances the pointer. An underflowing pop returns the entry in the slot below the wrapped pointer, and the pointer moves down by one.
- R9: sys_rst empties the stack. A push or pop in the same cycle as sys_rst is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst | input | 1 | Synchronous system reset; empties the stack, keeps the flags |
| push_en | input | 1 | Push strobe (call or interrupt entry) |
| pop_en | input | 1 | Pop strobe (return) |
| push_addr | input | 15 | Return address to store |
| top_addr | output | 15 | Current top entry; the value a pop returns |
| fault_rst_en | input | 1 | When high, a fault requests a reset and is blocked |
| flag_clr | input | 1 | Clears both sticky flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request after a fault with fault_rst_en high |

## Verification
The assertions assume that the strobes and the enable change only between clock edges, and that no check is needed while rst_n is low. They also assume that the core does not rely on the value of top_addr when no entry has yet been written to the slot it shows. The checker keeps its own depth count from the strobes, so its view of "full" and "empty" does not come from the design. The stimulus drives every input just after a rising edge. It compares popped data only for slots it has written, including the wrapped slot that the underflow case reads.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  localparam int unsigned RS_ADDR_W = 15;
  localparam int unsigned RS_DEPTH  = 16;

  // stack operation decoded from the two strobes
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } rs_op_e;
endpackage

// File: rtl/retstack_ptr.sv
module retstack_ptr
  import retstack_pkg::*;
#(
  parameter int unsigned DEPTH = RS_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic             fault_rst_en,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             ovf_evt,
  output logic             unf_evt
);
  rs_op_e           op;
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q;
  logic             is_full, is_empty, hold;

  assign op       = sys_rst ? OP_IDLE : rs_op_e'({push_en, pop_en});
  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign is_empty = (cnt_q == '0);

  // wrap-around neighbours of the pointer (works for any depth)
  assign ptr_inc = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? PTR_W'(DEPTH - 1) : ptr_q - 1'b1;

  assign ovf_evt = (op == OP_PUSH) && is_full;
  assign unf_evt = ((op == OP_POP) || (op == OP_SWAP)) && is_empty;
  assign hold    = fault_rst_en && (ovf_evt || unf_evt);

  assign wr_en  = !hold && ((op == OP_PUSH) || (op == OP_SWAP));
  assign wr_idx = (op == OP_SWAP) ? ptr_dec : ptr_q;
  assign rd_idx = ptr_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (sys_rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (!hold) begin
      unique case (op)
        OP_PUSH: begin
          ptr_q <= ptr_inc;
          if (!is_full) cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          ptr_q <= ptr_dec;
          if (!is_empty) cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/retstack_mem.sv
module retstack_mem
  import retstack_pkg::*;
#(
  parameter int unsigned DEPTH  = RS_DEPTH,
  parameter int unsigned DATA_W = RS_ADDR_W,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PTR_W'(g))) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/retstack_fault.sv
module retstack_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic unf_evt,
  input  logic fault_rst_en,
  input  logic flag_clr,
  output logic ovf_flag,
  output logic unf_flag,
  output logic rst_req
);
  // only power-on reset touches these; the system reset does not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (ovf_evt)       ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
      if (unf_evt)       unf_flag <= 1'b1;
      else if (flag_clr) unf_flag <= 1'b0;
      rst_req <= fault_rst_en && (ovf_evt || unf_evt);
    end
  end
endmodule

// File: rtl/retstack_top.sv
module retstack_top
  import retstack_pkg::*;
#(
  parameter int unsigned DEPTH  = RS_DEPTH,
  parameter int unsigned ADDR_W = RS_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst,
  input  logic              push_en,
  input  logic              pop_en,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr,
  input  logic              fault_rst_en,
  input  logic              flag_clr,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              rst_req
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             wr_en, ovf_evt, unf_evt;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  retstack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .push_en(push_en), .pop_en(pop_en), .fault_rst_en(fault_rst_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  retstack_mem #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(push_addr),
    .rd_idx(rd_idx), .rd_data(top_addr)
  );

  retstack_fault u_fault (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .fault_rst_en(fault_rst_en), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );
endmodule

// File: rtl/retstack_chk.sv
module retstack_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst,
  input logic              push_en,
  input logic              pop_en,
  input logic [ADDR_W-1:0] push_addr,
  input logic [ADDR_W-1:0] top_addr,
  input logic              fault_rst_en,
  input logic              flag_clr,
  input logic              ovf_flag,
  input logic              unf_flag,
  input logic              rst_req
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // independent depth count taken from the strobes alone
  logic [CNT_W-1:0] depth_s;
  logic full_s, empty_s, ovf_s, unf_s;
  assign full_s  = (depth_s == CNT_W'(DEPTH));
  assign empty_s = (depth_s == '0);
  assign ovf_s   = !sys_rst && push_en && !pop_en && full_s;
  assign unf_s   = !sys_rst && pop_en && empty_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || sys_rst)                          depth_s <= '0;
    else if (fault_rst_en && (ovf_s || unf_s))      depth_s <= depth_s;
    else if (push_en && !pop_en && !full_s)         depth_s <= depth_s + 1'b1;
    else if (pop_en && !push_en && !empty_s)        depth_s <= depth_s - 1'b1;
  end

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en && !sys_rst && !(fault_rst_en && full_s))
    |=> (top_addr == $past(push_addr))); // R2

  AST_SWAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en && !sys_rst && !(fault_rst_en && empty_s))
    |=> (top_addr == $past(push_addr))); // R3

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_s |=> ovf_flag); // R4

  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    unf_s |=> unf_flag); // R5

  AST_REQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rst_en && (ovf_s || unf_s)) |=> rst_req); // R6

  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_rst_en |=> !rst_req); // R6

  AST_BLOCKED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rst_en && ovf_s) |=> $stable(top_addr)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R7

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !flag_clr) |=> unf_flag); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_s && !unf_s) |=> (!ovf_flag && !unf_flag)); // R7
endmodule

bind retstack_top retstack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .push_en(push_en),
  .pop_en(pop_en), .push_addr(push_addr), .top_addr(top_addr),
  .fault_rst_en(fault_rst_en), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
  .unf_flag(unf_flag), .rst_req(rst_req)
);

// File: tb/retstack_tb.sv
module retstack_top_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, sys_rst = 1'b0;
  logic          push_en = 1'b0, pop_en = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] top_addr;
  logic          fault_rst_en = 1'b0, flag_clr = 1'b0;
  logic          ovf_flag, unf_flag, rst_req;

  int  n_checks = 0, n_errors = 0;
  bit  done = 1'b0;
  bit  mon_chk = 1'b0;
  logic [AW-1:0] exp_q [$];
  logic [AW-1:0] mdl [$];

  always #4 clk = ~clk; // 125 MHz

  retstack_top dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .push_en(push_en),
    .pop_en(pop_en), .push_addr(push_addr), .top_addr(top_addr),
    .fault_rst_en(fault_rst_en), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // monitor: compares the popped word with the scoreboard entry
  always @(negedge clk) begin
    if (pop_en && mon_chk) begin
      if (exp_q.size() == 0) check("R2 scoreboard empty", '1, '0);
      else check("R2/R3/R8 pop data", top_addr, exp_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_push(input logic [AW-1:0] v);
    push_en = 1'b1; push_addr = v; mdl.push_back(v);
    cyc();
    push_en = 1'b0;
  endtask

  task automatic do_pop(input logic [AW-1:0] exp, input bit chk);
    if (chk) exp_q.push_back(exp);
    mon_chk = chk; pop_en = 1'b1;
    cyc();
    pop_en = 1'b0; mon_chk = 1'b0;
    if (mdl.size() > 0) void'(mdl.pop_back());
  endtask

  task automatic pop_model();
    logic [AW-1:0] e;
    e = mdl[$];
    do_pop(e, 1'b1);
  endtask

  task automatic do_swap(input logic [AW-1:0] v);
    exp_q.push_back(mdl[$]);
    mon_chk = 1'b1; push_en = 1'b1; pop_en = 1'b1; push_addr = v;
    cyc();
    push_en = 1'b0; pop_en = 1'b0; mon_chk = 1'b0;
    mdl[mdl.size() - 1] = v;
  endtask

  task automatic pulse_sys_rst();
    sys_rst = 1'b1; cyc(); sys_rst = 1'b0;
    mdl.delete();
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 ovf_flag", AW'(ovf_flag), 0);
    check("R1 unf_flag", AW'(unf_flag), 0);
    check("R1 rst_req",  AW'(rst_req), 0);

    // R2 plain LIFO order
    for (int i = 0; i < 5; i++) begin
      do_push(AW'(15'h0A10 + i * 7));
      check("R2 top after push", top_addr, AW'(15'h0A10 + i * 7));
    end
    for (int i = 0; i < 5; i++) pop_model();
    check("R2 no flag on normal use", AW'(ovf_flag | unf_flag), 0);

    // R3 simultaneous push and pop replaces the top
    do_push(15'h1111); do_push(15'h2222); do_push(15'h3333);
    do_swap(15'h4444);
    check("R3 top replaced", top_addr, 15'h4444);
    pop_model(); pop_model(); pop_model();
    check("R3 depth unchanged, no underflow", AW'(unf_flag), 0);

    // R4/R8 overflow with fault reset disabled: wrap and overwrite oldest
    for (int i = 0; i < DEPTH; i++) do_push(AW'(15'h0100 + i));
    check("R4 no flag at exactly full", AW'(ovf_flag), 0);
    do_push(15'h5ABC);
    check("R4 ovf_flag set", AW'(ovf_flag), 1);
    check("R6 no request when disabled", AW'(rst_req), 0);
    check("R8 top is overflowing value", top_addr, 15'h5ABC);
    do_pop(15'h5ABC, 1'b1);
    for (int i = DEPTH - 1; i >= 1; i--) do_pop(AW'(15'h0100 + i), 1'b1);
    check("R5 not yet underflowed", AW'(unf_flag), 0);
    // R5/R8 underflow returns slot below the wrapped pointer
    do_pop(15'h5ABC, 1'b1);
    check("R5 unf_flag set", AW'(unf_flag), 1);
    check("R6 no request on underflow when disabled", AW'(rst_req), 0);
    // R7 sticky until clear
    cyc(); cyc();
    check("R7 ovf_flag sticky", AW'(ovf_flag), 1);
    pulse_clr();
    check("R7 ovf cleared", AW'(ovf_flag), 0);
    check("R7 unf cleared", AW'(unf_flag), 0);

    // R9 system reset empties the stack
    mdl.delete();
    do_push(15'h0777); do_push(15'h0778);
    pulse_sys_rst();
    check("R9 flags untouched", AW'(ovf_flag | unf_flag), 0);
    do_pop('0, 1'b0);
    check("R9 pop after sys_rst underflows", AW'(unf_flag), 1);
    pulse_clr();
    // R9 strobe ignored during sys_rst
    sys_rst = 1'b1; push_en = 1'b1; push_addr = 15'h0999; cyc();
    sys_rst = 1'b0; push_en = 1'b0;
    do_pop('0, 1'b0);
    check("R9 push during sys_rst ignored", AW'(unf_flag), 1);
    pulse_clr();
    pulse_sys_rst();

    // R6 fault reset enabled: overflow is blocked and requests reset
    fault_rst_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) do_push(AW'(15'h0200 + i));
    push_en = 1'b1; push_addr = 15'h6000; cyc(); push_en = 1'b0;
    check("R6 rst_req pulse", AW'(rst_req), 1);
    check("R4 ovf with enable", AW'(ovf_flag), 1);
    check("R6 storage unchanged", top_addr, 15'h020F);
    cyc();
    check("R6 rst_req one cycle", AW'(rst_req), 0);
    do_pop(15'h020F, 1'b1);
    do_pop(15'h020E, 1'b1);
    pulse_sys_rst();
    check("R7 ovf survives sys_rst", AW'(ovf_flag), 1);
    do_pop('0, 1'b0);
    check("R6 rst_req on underflow", AW'(rst_req), 1);
    check("R5 unf with enable", AW'(unf_flag), 1);
    fault_rst_en = 1'b0;

    // R7 a set wins over a clear in the same cycle
    flag_clr = 1'b1; pop_en = 1'b1; cyc(); flag_clr = 1'b0; pop_en = 1'b0;
    check("R7 set beats clear", AW'(unf_flag), 1);
    check("R7 other flag cleared", AW'(ovf_flag), 0);

    // R1 power-on reset clears the flags
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    check("R1 por clears unf", AW'(unf_flag), 0);
    check("R1 por clears req", AW'(rst_req), 0);

    cyc();
    finish_run();
  end
endmodule